// File: doc/BRIEF.md
# Four-Channel DMA Host Register Interface

This block is the register file and command decoder that a host processor uses to program a four-channel DMA controller through an 8-bit port. The host drives a 4-bit port offset with a write or read strobe. The eight lowest offsets reach the per-channel 16-bit address and word-count registers. Each of these registers is moved one byte at a time, and a single shared byte pointer picks the low byte or the high byte. The upper offsets reach the shared control registers. Three of those offsets are data-less command strobes that reset the byte pointer, perform a master clear, or unmask every channel.

The arbiter and the transfer engine see the programmed state through dedicated outputs: the current address and count of each channel, each channel's mode, the mask and software-request bits, and the command byte. The engine pulses a per-channel `step` input once for each transferred word. On that pulse the block moves the current address, decrements the current count, flags terminal count when the count wraps past zero, and reloads the base values when the channel is set to auto-initialize.

Top module: `dma_regif`

## Requirements
- R1: After synchronous reset, all mask bits are 1. The command, status, request and temporary registers, every address and count register, and the byte pointer are all 0.
- R2: A write to offset 2n (n = 0..3) loads a byte into both the base and the current address of channel n: the low byte when the byte pointer is 0, the high byte when it is 1. A read at offset 2n returns the matching byte of the current address.
- R3: A write to offset 2n+1 loads a byte of the base and current word count of channel n in the same way, and a read at offset 2n+1 returns the matching byte of the current count.
- R4: Every read or write at offsets 0..7 toggles the one byte pointer that all channels and both register kinds share. Any write to offset 0xC clears the pointer whatever the data.
- R5: A write to offset 8 loads the 8-bit command register, which appears on `cmd_o`.
- R6: A write to offset 0xB loads the mode of the channel named by data bits 1:0. `mode_o` slice n holds data bits 7:2 of that write. Within the slice, bit 2 is auto-initialize and bit 3 is address decrement.
- R7: A write to offset 0xA changes only the mask bit of the channel named by data bits 1:0. Data bit 2 = 1 sets it and 0 clears it. Data bits 7:3 are ignored.
- R8: A write to offset 0xF loads all four mask bits from data bits 3:0, with bit n for channel n. Any write to offset 0xE clears all four mask bits whatever the data.
- R9: A write to offset 9 sets or clears the software request of the channel named by data bits 1:0, according to data bit 2.
- R10: A read at offset 8 returns the terminal-count flags in bits 3:0 and the pending requests (`hw_req` OR software request) in bits 7:4. The read clears the terminal-count flags. A terminal count that arrives in the same cycle as the read survives that read.
- R11: Any write to offset 0xD sets all mask bits. It also zeroes the command, terminal-count flags, software requests, temporary register and byte pointer. Modes, addresses and counts are left unchanged.
- R12: On `step[n]`, the current count of channel n decrements and the current address moves by one, up or down as the mode selects. When the count was 0, `tc_o[n]` pulses and the terminal-count flag is set. In that case, if auto-initialize is on, the current address and count reload from base; otherwise the count becomes 0xFFFF.
- R13: `temp_ld` loads `temp_din` into the temporary register, and a read at offset 0xB returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_off | input | 4 | Host port offset |
| wr_en | input | 1 | Host write strobe (wins over `rd_en`) |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the strobe cycle, 0 when idle |
| step | input | 4 | One transferred word per channel, from the engine |
| hw_req | input | 4 | Hardware request lines, shown in status |
| temp_ld | input | 1 | Load strobe for the temporary register |
| temp_din | input | 8 | Temporary register data from the engine |
| cur_addr_o | output | 64 | Current address, 16 bits per channel |
| cur_cnt_o | output | 64 | Current word count, 16 bits per channel |
| mode_o | output | 24 | Mode (write bits 7:2), 6 bits per channel |
| mask_o | output | 4 | Channel mask bits |
| sw_req_o | output | 4 | Software request bits |
| cmd_o | output | 8 | Command register |
| tc_o | output | 4 | Terminal-count pulse per channel |

## Verification
The bench goes after the shared byte pointer. It interleaves accesses to different channels and register kinds, and clears the pointer mid-word. A design that kept one pointer per register, or ignored the 0xC strobe, would then put bytes in the wrong halves. It sweeps every single-mask, request and four-bit mask code with junk in the unused bits, so a decoder that looked at extra bits would corrupt other channels. It also steps counts through zero in both address directions, with and without auto-initialize, and reads status in the very cycle a terminal count arrives. A design that let the read-clear win would lose that flag, and one that missed the reload would leave 0xFFFF behind.

// File: rtl/dma_regif_pkg.sv
// Shared constants and types for the DMA host register interface.
// Assumes a fixed four-channel, 16-bit register layout decoded from
// a 4-bit port offset.
package dma_regif_pkg;
    localparam int NCH = 4;            // channels
    localparam int WW  = 16;           // address / count width
    localparam int DW  = 8;            // host port width
    localparam int MW  = 6;            // stored mode bits (write bits 7:2)
    localparam int CSW = $clog2(NCH);  // channel select width

    localparam logic [3:0] OFF_CMD   = 4'h8;
    localparam logic [3:0] OFF_REQ   = 4'h9;
    localparam logic [3:0] OFF_SMASK = 4'hA;
    localparam logic [3:0] OFF_MODE  = 4'hB;
    localparam logic [3:0] OFF_CLRFF = 4'hC;
    localparam logic [3:0] OFF_MCLR  = 4'hD;
    localparam logic [3:0] OFF_CLRMK = 4'hE;
    localparam logic [3:0] OFF_AMASK = 4'hF;

    typedef logic [WW-1:0] word_t;
    typedef logic [MW-1:0] mode_t;
endpackage

// File: rtl/dma_byteptr.sv
// Shared low/high byte pointer for all 16-bit registers.
// Assumes clear has priority over toggle.
module dma_byteptr (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic clear,
    output logic hi
);
    // Pointer state: cleared by reset or command, flipped per access.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hi <= 1'b0;
        else if (toggle)     hi <= ~hi;
    end

    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !clear) |=> (hi != $past(hi)));
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hi);
endmodule

// File: rtl/dma_chan_regs.sv
// Base and current address/count registers of one channel.
// Host byte writes load base and current together; a step pulse
// advances the current pair. Host writes win over a step on the
// same register.
module dma_chan_regs
    import dma_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic          hi,
    input  logic [DW-1:0] wbyte,
    input  logic          step,
    input  logic          dec,
    input  logic          autoinit,
    output word_t         cur_addr,
    output word_t         cur_cnt,
    output logic          tc
);
    localparam int HB = WW - DW;   // low bit of the high byte

    word_t base_addr, base_cnt;
    logic  wrap;

    assign wrap = (cur_cnt == '0);
    assign tc   = step && wrap;

    // Address pair: host byte load, else step move or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (addr_we) begin
            if (hi) begin
                base_addr[WW-1:HB] <= wbyte;
                cur_addr[WW-1:HB]  <= wbyte;
            end else begin
                base_addr[DW-1:0] <= wbyte;
                cur_addr[DW-1:0]  <= wbyte;
            end
        end else if (step) begin
            if (wrap && autoinit) cur_addr <= base_addr;
            else if (dec)         cur_addr <= cur_addr - 1'b1;
            else                  cur_addr <= cur_addr + 1'b1;
        end
    end

    // Count pair: host byte load, else step decrement or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (cnt_we) begin
            if (hi) begin
                base_cnt[WW-1:HB] <= wbyte;
                cur_cnt[WW-1:HB]  <= wbyte;
            end else begin
                base_cnt[DW-1:0] <= wbyte;
                cur_cnt[DW-1:0]  <= wbyte;
            end
        end else if (step) begin
            if (wrap && autoinit) cur_cnt <= base_cnt;
            else                  cur_cnt <= cur_cnt - 1'b1;
        end
    end

    a_r12_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_we && !wrap) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
    a_r12_wrap_ffff: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_we && wrap && !autoinit) |=> (cur_cnt == '1));
    a_r12_addr_move: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_we && !(wrap && autoinit)) |=>
        (cur_addr == (dec ? $past(cur_addr) - 1'b1 : $past(cur_addr) + 1'b1)));
endmodule

// File: rtl/dma_ctrl_regs.sv
// Shared control state: command, per-channel modes, mask, software
// requests, terminal-count flags and temporary register.
// Assumes at most one write strobe is active per cycle (decoded upstream).
module dma_ctrl_regs
    import dma_regif_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  wdata,
    input  logic           cmd_we,
    input  logic           req_we,
    input  logic           smask_we,
    input  logic           amask_we,
    input  logic           mode_we,
    input  logic           clrmask,
    input  logic           mclr,
    input  logic           stat_rd,
    input  logic           temp_ld,
    input  logic [DW-1:0]  temp_din,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] hw_req,
    output logic [DW-1:0]  cmd,
    output mode_t          mode [NCH],
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] sw_req,
    output logic [DW-1:0]  status,
    output logic [DW-1:0]  temp
);
    logic [NCH-1:0] tc_q;
    logic [CSW-1:0] csel;

    assign csel   = wdata[CSW-1:0];
    assign status = {hw_req | sw_req, tc_q};

    // Command register.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) cmd <= '0;
        else if (cmd_we)    cmd <= wdata;
    end

    // Mask bits: master clear sets, clear-mask zeroes, whole or single writes.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)  mask <= '1;
        else if (clrmask)    mask <= '0;
        else if (amask_we)   mask <= wdata[NCH-1:0];
        else if (smask_we)   mask[csel] <= wdata[2];
    end

    // Software request bits.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) sw_req <= '0;
        else if (req_we)    sw_req[csel] <= wdata[2];
    end

    // Terminal-count flags: cleared by status read, new arrivals win.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) tc_q <= '0;
        else                tc_q <= (stat_rd ? '0 : tc_q) | tc_set;
    end

    // Temporary register loaded by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) temp <= '0;
        else if (temp_ld)   temp <= temp_din;
    end

    // One mode register per channel, picked by the channel field.
    for (genvar g = 0; g < NCH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode[g] <= '0;
            else if (mode_we && csel == CSW'(g))
                mode[g] <= wdata[DW-1:DW-MW];
        end
    end

    a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (smask_we && !mclr && !clrmask && !amask_we) |=>
        ($countones(mask ^ $past(mask)) <= 1));
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clrmask && !mclr) |=> (mask == '0));
    a_r10_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclr && |tc_set) |=> ((status[NCH-1:0] & $past(tc_set)) == $past(tc_set)));
    a_r11_mclr: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask == '1 && cmd == '0 && sw_req == '0 && temp == '0));
endmodule

// File: rtl/dma_regif.sv
// Top of the DMA host register interface: decodes port offset and
// strobes, owns the read multiplexer, and instances the byte pointer,
// the per-channel registers and the shared control registers.
// Assumes a write strobe takes precedence over a simultaneous read.
module dma_regif
    import dma_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         port_off,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NCH-1:0]     step,
    input  logic [NCH-1:0]     hw_req,
    input  logic               temp_ld,
    input  logic [DW-1:0]      temp_din,
    output logic [NCH*WW-1:0]  cur_addr_o,
    output logic [NCH*WW-1:0]  cur_cnt_o,
    output logic [NCH*MW-1:0]  mode_o,
    output logic [NCH-1:0]     mask_o,
    output logic [NCH-1:0]     sw_req_o,
    output logic [DW-1:0]      cmd_o,
    output logic [NCH-1:0]     tc_o
);
    logic           rd, wide, hi, mclr, stat_rd;
    logic [CSW-1:0] ch;
    word_t          cur_addr [NCH];
    word_t          cur_cnt  [NCH];
    mode_t          mode     [NCH];
    word_t          sel;
    logic [DW-1:0]  status, temp;

    assign rd      = rd_en && !wr_en;
    assign wide    = !port_off[3];
    assign ch      = port_off[CSW:1];
    assign mclr    = wr_en && port_off == OFF_MCLR;
    assign stat_rd = rd && port_off == OFF_STAT_RD;

    localparam logic [3:0] OFF_STAT_RD = OFF_CMD;

    dma_byteptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle ((wr_en || rd_en) && wide),
        .clear  ((wr_en && port_off == OFF_CLRFF) || mclr),
        .hi     (hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_we  (wr_en && wide && !port_off[0] && ch == CSW'(g)),
            .cnt_we   (wr_en && wide &&  port_off[0] && ch == CSW'(g)),
            .hi       (hi),
            .wbyte    (wdata),
            .step     (step[g]),
            .dec      (mode[g][3]),
            .autoinit (mode[g][2]),
            .cur_addr (cur_addr[g]),
            .cur_cnt  (cur_cnt[g]),
            .tc       (tc_o[g])
        );
        assign cur_addr_o[g*WW +: WW] = cur_addr[g];
        assign cur_cnt_o[g*WW +: WW]  = cur_cnt[g];
        assign mode_o[g*MW +: MW]     = mode[g];
    end

    dma_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (wdata),
        .cmd_we   (wr_en && port_off == OFF_CMD),
        .req_we   (wr_en && port_off == OFF_REQ),
        .smask_we (wr_en && port_off == OFF_SMASK),
        .amask_we (wr_en && port_off == OFF_AMASK),
        .mode_we  (wr_en && port_off == OFF_MODE),
        .clrmask  (wr_en && port_off == OFF_CLRMK),
        .mclr     (mclr),
        .stat_rd  (stat_rd),
        .temp_ld  (temp_ld),
        .temp_din (temp_din),
        .tc_set   (tc_o),
        .hw_req   (hw_req),
        .cmd      (cmd_o),
        .mode     (mode),
        .mask     (mask_o),
        .sw_req   (sw_req_o),
        .status   (status),
        .temp     (temp)
    );

    // Read multiplexer: byte of a channel register, status or temporary.
    always_comb begin
        sel   = port_off[0] ? cur_cnt[ch] : cur_addr[ch];
        rdata = '0;
        if (rd) begin
            if (wide)                       rdata = hi ? sel[WW-1:WW-DW] : sel[DW-1:0];
            else if (port_off == OFF_CMD)   rdata = status;
            else if (port_off == OFF_MODE)  rdata = temp;
        end
    end

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: tb/dma_regif_tb.sv
module dma_regif_tb;
    import dma_regif_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         port_off = '0;
    logic               wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]         wdata = '0;
    logic [7:0]         rdata;
    logic [3:0]         step = '0, hw_req = '0;
    logic               temp_ld = 1'b0;
    logic [7:0]         temp_din = '0;
    logic [63:0]        cur_addr_o, cur_cnt_o;
    logic [23:0]        mode_o;
    logic [3:0]         mask_o, sw_req_o, tc_o;
    logic [7:0]         cmd_o;

    int total = 0, fails = 0;
    logic [3:0] em, er;

    always #2.5 clk = ~clk;

    dma_regif u_dut (
        .clk(clk), .rst_n(rst_n), .port_off(port_off), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .step(step),
        .hw_req(hw_req), .temp_ld(temp_ld), .temp_din(temp_din),
        .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o), .mode_o(mode_o),
        .mask_o(mask_o), .sw_req_o(sw_req_o), .cmd_o(cmd_o), .tc_o(tc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        port_off = off; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        port_off = off; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] off, input logic [15:0] v);
        wr(off, v[7:0]);
        wr(off, v[15:8]);
    endtask

    task automatic rd16(input logic [3:0] off, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(off, lo);
        rd(off, hi);
        v = {hi, lo};
    endtask

    task automatic pulse_step(input logic [3:0] s);
        @(negedge clk);
        step = s;
        @(negedge clk);
        step = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: all R, actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mask", {28'd0, mask_o}, 32'hF);
        check("R1 cmd", {24'd0, cmd_o}, 32'h0);
        rd(4'h8, b);  check("R1 status", {24'd0, b}, 32'h0);
        rd16(4'h6, v); check("R1 addr ch3", {16'd0, v}, 32'h0);

        // R2 / R3: all channels, several patterns
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic [15:0] a, c;
                a = 16'h1234 * (p + 1) + 16'h1111 * n;
                c = 16'hF00F ^ (16'h0321 * (n + 1)) ^ (p << 7);
                wr16(4'(2 * n), a);
                wr16(4'(2 * n + 1), c);
            end
            for (int n = 0; n < 4; n++) begin
                logic [15:0] a, c;
                a = 16'h1234 * (p + 1) + 16'h1111 * n;
                c = 16'hF00F ^ (16'h0321 * (n + 1)) ^ (p << 7);
                rd16(4'(2 * n), v);     check("R2 addr read", {16'd0, v}, {16'd0, a});
                check("R2 addr out", {16'd0, cur_addr_o[n*16 +: 16]}, {16'd0, a});
                rd16(4'(2 * n + 1), v); check("R3 count read", {16'd0, v}, {16'd0, c});
                check("R3 count out", {16'd0, cur_cnt_o[n*16 +: 16]}, {16'd0, c});
            end
        end

        // R4: pointer cleared mid-word by offset C (data ignored)
        wr(4'h0, 8'hAA);
        wr(4'hC, 8'hFF);
        wr16(4'h0, 16'h5566);
        rd16(4'h0, v); check("R4 clear ff", {16'd0, v}, 32'h5566);
        // R4: pointer shared across channels and register kinds
        wr16(4'h5, 16'h0077);
        wr(4'h2, 8'h11);          // low byte of ch1 addr, pointer -> 1
        wr(4'h5, 8'h22);          // high byte of ch2 count
        rd16(4'h5, v); check("R4 shared ff write", {16'd0, v}, 32'h2277);
        rd(4'h0, b);              // pointer -> 1
        rd(4'h5, b);  check("R4 shared ff read", {24'd0, b}, 32'h22);

        // R5 command
        for (int i = 0; i < 8; i++) begin
            wr(4'h8, 8'(1 << i) ^ 8'h5A);
            check("R5 cmd", {24'd0, cmd_o}, {24'd0, 8'(1 << i) ^ 8'h5A});
        end

        // R6 mode per channel
        for (int n = 0; n < 4; n++) wr(4'hB, 8'(((n * 8'h3C + 8'h44) & 8'hFC) | n));
        for (int n = 0; n < 4; n++)
            check("R6 mode", {26'd0, mode_o[n*6 +: 6]},
                  {26'd0, 6'((((n * 8'h3C + 8'h44) & 8'hFC)) >> 2)});

        // R8 all-mask sweep and clear-mask
        for (int v4 = 0; v4 < 16; v4++) begin
            wr(4'hF, 8'hA0 | 8'(v4));
            check("R8 all mask", {28'd0, mask_o}, 32'(v4));
        end
        wr(4'hE, 8'h00);
        check("R8 clear mask", {28'd0, mask_o}, 32'h0);
        em = 4'h0;

        // R7 single mask sweep, junk in bits 7:3
        for (int k = 0; k < 8; k++) begin
            wr(4'hA, 8'hF8 | 8'(k));
            em[k[1:0]] = k[2];
            check("R7 single mask", {28'd0, mask_o}, {28'd0, em});
        end
        for (int k = 7; k >= 0; k--) begin
            wr(4'hA, 8'h08 | 8'(k ^ 4));
            em[k[1:0]] = ~k[2];
            check("R7 single mask rev", {28'd0, mask_o}, {28'd0, em});
        end

        // R9 request sweep and R10 status upper bits
        er = 4'h0;
        hw_req = 4'b1000;
        for (int k = 0; k < 8; k++) begin
            int kk;
            kk = (k * 5) & 7;
            wr(4'h9, 8'hE8 | 8'(kk));
            er[kk[1:0]] = kk[2];
            check("R9 request", {28'd0, sw_req_o}, {28'd0, er});
        end
        rd(4'h8, b);
        check("R10 pending", {24'd0, b}, {24'd0, (er | 4'b1000), 4'h0});
        wr(4'h9, 8'h00); wr(4'h9, 8'h01); wr(4'h9, 8'h02); wr(4'h9, 8'h03);
        hw_req = 4'h0;

        // R12 step: ch0 increment, no auto-init
        wr(4'hB, 8'h84);
        wr16(4'h0, 16'h1000);
        wr16(4'h1, 16'h0002);
        pulse_step(4'b0001);
        pulse_step(4'b0001);
        check("R12 no tc yet", {16'd0, cur_cnt_o[15:0]}, 32'h0);
        @(negedge clk); step = 4'b0001; #1;
        check("R12 tc pulse", {28'd0, tc_o}, 32'h1);
        @(negedge clk); step = 4'b0000;
        check("R12 inc addr", {16'd0, cur_addr_o[15:0]}, 32'h1003);
        check("R12 wrap ffff", {16'd0, cur_cnt_o[15:0]}, 32'hFFFF);
        rd(4'h8, b);  check("R10 tc flag", {24'd0, b}, 32'h01);
        rd(4'h8, b);  check("R10 read clears", {24'd0, b}, 32'h00);

        // R12 ch1 decrement with auto-init
        wr(4'hB, 8'h31);
        wr16(4'h2, 16'h2000);
        wr16(4'h3, 16'h0001);
        pulse_step(4'b0010);
        check("R12 dec addr", {16'd0, cur_addr_o[31:16]}, 32'h1FFF);
        check("R12 dec count", {16'd0, cur_cnt_o[31:16]}, 32'h0);
        pulse_step(4'b0010);
        check("R12 autoinit addr", {16'd0, cur_addr_o[31:16]}, 32'h2000);
        check("R12 autoinit count", {16'd0, cur_cnt_o[31:16]}, 32'h1);
        rd(4'h8, b);  check("R10 tc ch1", {24'd0, b}, 32'h02);

        // R10: tc arriving in the same cycle as the status read survives
        wr16(4'h7, 16'h0000);
        @(negedge clk);
        port_off = 4'h8; rd_en = 1'b1; step = 4'b1000;
        #1 check("R10 old status", {24'd0, rdata}, 32'h00);
        @(negedge clk);
        rd_en = 1'b0; step = 4'b0000;
        rd(4'h8, b);  check("R10 same-cycle tc", {24'd0, b}, 32'h08);

        // R13 temporary register
        @(negedge clk); temp_ld = 1'b1; temp_din = 8'hC3;
        @(negedge clk); temp_ld = 1'b0;
        rd(4'hB, b);  check("R13 temp", {24'd0, b}, 32'hC3);

        // R11 master clear
        wr(4'h8, 8'h55);
        wr(4'hE, 8'h00);
        wr(4'h9, 8'h06);
        wr16(4'h4, 16'hBEEF);
        pulse_step(4'b0001);       // ch0 count 0xFFFF -> no tc; ensure flags clean
        wr(4'h0, 8'h99);           // pointer -> 1, ch0 addr low = 99
        wr(4'hD, 8'hA5);
        check("R11 mask set", {28'd0, mask_o}, 32'hF);
        check("R11 cmd zero", {24'd0, cmd_o}, 32'h0);
        check("R11 req zero", {28'd0, sw_req_o}, 32'h0);
        rd(4'hB, b);  check("R11 temp zero", {24'd0, b}, 32'h0);
        rd16(4'h4, v); check("R11 ff zero, addr kept", {16'd0, v}, 32'hBEEF);
        check("R11 mode kept", {26'd0, mode_o[11:6]}, 32'h0C);
        rd(4'h8, b);  check("R11 status zero", {24'd0, b}, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule